// File: doc/BRIEF.md
# Paged Index/Data Configuration Port

This block sits on the processor's I/O request path and gives software access to a small set of on-chip configuration registers through two I/O addresses: one that selects a register index and one that moves the data. A write to the selector address latches an 8-bit index. The next access to the data address reads or writes the register that the index names, provided the index is currently visible and implemented. Any data access without a pending index, or with an index that does not resolve to an on-chip register, is handed off to the external bus. Accesses that are handled on chip are flagged as hits and produce no external cycle.

A 4-bit page field selects which indices are visible. Page value 0001 opens the extended range of indices. Every other value leaves only the base window open. A sticky lock bit guards the system-management configuration fields: the region enable, the NMI enable, the management-mode select and the region base bytes. While the lock is set, those fields change only when the `in_smm` input is high. Reset clears every register. The init input keeps all registers and only cancels a pending index.

Top module: `cfg_index_port`

## Requirements
- R1: An access to the data address (default 23h) while no index is pending gives `io_fwd`=1 and `io_hit`=0.
- R2: A read of the index address (default 22h) is always forwarded (`io_fwd`=1). A write to it is absorbed (`io_hit`=1) and latches `io_wdata` as the pending index.
- R3: Every data-address access consumes the pending index. A second data access that has no new index write in between is forwarded.
- R4: Visibility depends on the page field. With page 0000, or any value other than 0001, only indices C0h–CFh and FCh–FFh are visible. With page 0001, all indices are visible. Index EAh (management-mode select, bit 0) is reachable only with page 0001.
- R5: The implemented registers are the following:
  - C1h: region enable in bit 7.
  - C3h: page field in bits 7:4, NMI enable in bit 1, lock in bit 0.
  - C4h+k: base byte k, which drives `smm_base[8k+7:8k]`.
  - EAh: mode select in bit 0.
  
  Any other index, visible or not, is forwarded, and `io_rdata` reads 0. Unused bits read 0.
- R6: While the lock is 1 and `in_smm` is 0, writes leave the region enable, NMI enable, mode select and base bytes unchanged, but they still count as hits. When `in_smm` is 1, those writes take effect.
- R7: Once set, the lock stays 1 until reset. Writing 0 to C3h bit 0 does not clear it, even when `in_smm` is 1. The page field stays writable.
- R8: A pulse on `init` cancels the pending index and leaves every register unchanged.
- R9: After reset, all register outputs are 0, no index is pending, and `io_hit`, `io_fwd` and `io_rdata` are 0 while `io_valid` is 0.
- R10: `io_hit` and `io_fwd` are never both 1. Whenever `io_valid` is 1, exactly one of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Soft init; cancels the pending index only |
| io_valid | input | 1 | I/O request present this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | ADDR_W | I/O port address |
| io_wdata | input | 8 | Write data |
| in_smm | input | 1 | Processor is in system-management mode |
| io_hit | output | 1 | Access handled on chip |
| io_fwd | output | 1 | Access must go to the external bus |
| io_rdata | output | 8 | Read data for an on-chip read hit, else 0 |
| page_sel | output | 4 | Page field |
| smi_lock | output | 1 | Lock bit |
| nmi_en | output | 1 | NMI enable during management mode |
| smm_rgn_en | output | 1 | Management region enable |
| smm_mode | output | 1 | Management-mode select |
| smm_base | output | 8*BASE_BYTES | Management region base bytes |

## Verification
The bench targets the following faulty behaviours:
- An index that survives a data access. Such a design claims a second data access and fails to forward it.
- A page decode that lets EAh through in page 0000. This turns a forwarded read into a hit.
- A lock that guards too little or too much. This shows up as a protected field changing outside management mode, a write that is refused inside it, or a lock that clears itself.
- An init that disturbs registers, or one that fails to cancel the index. Either error shows in the forward flag and in the register pins after the pulse.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam logic [7:0] IX_RGN   = 8'hC1;
  localparam logic [7:0] IX_CTL   = 8'hC3;
  localparam logic [7:0] IX_BASE0 = 8'hC4;
  localparam logic [7:0] IX_MODE  = 8'hEA;
  localparam logic [3:0] PAGE_EXT = 4'b0001;
endpackage

// File: rtl/cfgp_index.sv
module cfgp_index (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       idx_wr,
  input  logic [7:0] idx_in,
  input  logic       consume,
  output logic [7:0] idx_q,
  output logic       idx_vld
);
  logic [7:0] idx_n;
  logic       vld_n;
  logic       idx_en;

  always_comb begin
    idx_en = idx_wr & ~init;
    idx_n  = idx_en ? idx_in : idx_q;
    if (init)         vld_n = 1'b0;
    else if (idx_wr)  vld_n = 1'b1;
    else if (consume) vld_n = 1'b0;
    else              vld_n = idx_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      idx_vld <= 1'b0;
    end else begin
      idx_vld <= vld_n;
      if (idx_en) idx_q <= idx_n;
    end
  end
endmodule

// File: rtl/cfgp_decode.sv
module cfgp_decode #(
  parameter int BASE_BYTES = 3
) (
  input  logic [7:0]            idx,
  input  logic                  idx_vld,
  input  logic [3:0]            page,
  output logic                  sel_rgn,
  output logic                  sel_ctl,
  output logic                  sel_mode,
  output logic [BASE_BYTES-1:0] sel_base,
  output logic                  sel_any
);
  import cfgp_pkg::*;
  logic base_win, ext, live;

  always_comb begin
    base_win = (idx[7:4] == 4'hC) || (idx[7:2] == 6'b111111);
    ext      = (page == PAGE_EXT);
    live     = idx_vld & (base_win | ext);
    sel_rgn  = live & (idx == IX_RGN);
    sel_ctl  = live & (idx == IX_CTL);
    sel_mode = live & ext & (idx == IX_MODE);
  end

  for (genvar k = 0; k < BASE_BYTES; k++) begin : g_bsel
    assign sel_base[k] = live & (idx == IX_BASE0 + 8'(k));
  end

  assign sel_any = sel_rgn | sel_ctl | sel_mode | (|sel_base);
endmodule

// File: rtl/cfgp_regs.sv
module cfgp_regs #(
  parameter int BASE_BYTES = 3,
  localparam int BASE_W = 8 * BASE_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [7:0]            wdata,
  input  logic                  in_smm,
  input  logic                  sel_rgn,
  input  logic                  sel_ctl,
  input  logic                  sel_mode,
  input  logic [BASE_BYTES-1:0] sel_base,
  output logic [7:0]            rd,
  output logic [3:0]            page_q,
  output logic                  lock_q,
  output logic                  nmi_q,
  output logic                  rgn_q,
  output logic                  mode_q,
  output logic [BASE_W-1:0]     base_q
);
  logic        prot_ok;
  logic        ctl_en, rgn_en, mode_en;
  logic [3:0]  page_n;
  logic        lock_n, nmi_n, rgn_n, mode_n;

  always_comb begin
    prot_ok = ~lock_q | in_smm;
    ctl_en  = we & sel_ctl;
    rgn_en  = we & sel_rgn & prot_ok;
    mode_en = we & sel_mode & prot_ok;
    page_n  = wdata[7:4];
    lock_n  = lock_q | wdata[0];
    nmi_n   = prot_ok ? wdata[1] : nmi_q;
    rgn_n   = wdata[7];
    mode_n  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      lock_q <= 1'b0;
      nmi_q  <= 1'b0;
      rgn_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (ctl_en) begin
        page_q <= page_n;
        lock_q <= lock_n;
        nmi_q  <= nmi_n;
      end
      if (rgn_en)  rgn_q  <= rgn_n;
      if (mode_en) mode_q <= mode_n;
    end
  end

  for (genvar k = 0; k < BASE_BYTES; k++) begin : g_base
    logic byte_en;
    assign byte_en = we & sel_base[k] & prot_ok;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       base_q[8*k +: 8] <= '0;
      else if (byte_en) base_q[8*k +: 8] <= wdata;
    end
  end

  always_comb begin
    rd = '0;
    if (sel_rgn)  rd = {rgn_q, 7'b0};
    if (sel_ctl)  rd = {page_q, 2'b0, nmi_q, lock_q};
    if (sel_mode) rd = {7'b0, mode_q};
    for (int k = 0; k < BASE_BYTES; k++)
      if (sel_base[k]) rd = base_q[8*k +: 8];
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port #(
  parameter int               ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0023,
  parameter int               BASE_BYTES = 3,
  localparam int              BASE_W     = 8 * BASE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              in_smm,
  output logic              io_hit,
  output logic              io_fwd,
  output logic [7:0]        io_rdata,
  output logic [3:0]        page_sel,
  output logic              smi_lock,
  output logic              nmi_en,
  output logic              smm_rgn_en,
  output logic              smm_mode,
  output logic [BASE_W-1:0] smm_base
);
  logic                  idx_wr, data_acc, data_hit;
  logic [7:0]            idx_q, rd;
  logic                  idx_vld;
  logic                  sel_rgn, sel_ctl, sel_mode, sel_any;
  logic [BASE_BYTES-1:0] sel_base;

  assign idx_wr   = io_valid & io_write & (io_addr == IDX_PORT);
  assign data_acc = io_valid & (io_addr == DATA_PORT);

  cfgp_index u_index (
    .clk(clk), .rst_n(rst_n), .init(init),
    .idx_wr(idx_wr), .idx_in(io_wdata), .consume(data_acc),
    .idx_q(idx_q), .idx_vld(idx_vld)
  );

  cfgp_decode #(.BASE_BYTES(BASE_BYTES)) u_decode (
    .idx(idx_q), .idx_vld(idx_vld), .page(page_sel),
    .sel_rgn(sel_rgn), .sel_ctl(sel_ctl), .sel_mode(sel_mode),
    .sel_base(sel_base), .sel_any(sel_any)
  );

  assign data_hit = data_acc & sel_any;

  cfgp_regs #(.BASE_BYTES(BASE_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(data_hit & io_write), .wdata(io_wdata), .in_smm(in_smm),
    .sel_rgn(sel_rgn), .sel_ctl(sel_ctl), .sel_mode(sel_mode),
    .sel_base(sel_base), .rd(rd),
    .page_q(page_sel), .lock_q(smi_lock), .nmi_q(nmi_en),
    .rgn_q(smm_rgn_en), .mode_q(smm_mode), .base_q(smm_base)
  );

  assign io_hit   = idx_wr | data_hit;
  assign io_fwd   = io_valid & ~io_hit;
  assign io_rdata = (data_hit & ~io_write) ? rd : 8'h00;
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int               ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0023,
  parameter int               BASE_W     = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init,
  input logic              io_valid,
  input logic              io_write,
  input logic [ADDR_W-1:0] io_addr,
  input logic              in_smm,
  input logic              io_hit,
  input logic              io_fwd,
  input logic              smi_lock,
  input logic              nmi_en,
  input logic              smm_rgn_en,
  input logic              smm_mode,
  input logic [BASE_W-1:0] smm_base
);
  AST_HIT_FWD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_hit && io_fwd)) else $error("hit and fwd together"); // R10

  AST_IDX_READ_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_write && io_addr == IDX_PORT) |-> io_fwd) else $error("index read claimed"); // R2

  AST_DATA_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_addr == DATA_PORT) |=> !(io_valid && io_addr == DATA_PORT && io_hit))
    else $error("index reused"); // R3

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    smi_lock |=> smi_lock) else $error("lock cleared"); // R7

  AST_LOCK_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_lock && !in_smm) |=> ($stable(smm_rgn_en) && $stable(nmi_en) &&
                               $stable(smm_mode) && $stable(smm_base)))
    else $error("protected field changed"); // R6

  AST_INIT_DROPS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> !(io_valid && io_addr == DATA_PORT && io_hit)) else $error("index kept over init"); // R8
endmodule

bind cfg_index_port cfgp_checker #(
  .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT), .BASE_W(BASE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .io_valid(io_valid), .io_write(io_write),
  .io_addr(io_addr), .in_smm(in_smm), .io_hit(io_hit), .io_fwd(io_fwd),
  .smi_lock(smi_lock), .nmi_en(nmi_en), .smm_rgn_en(smm_rgn_en),
  .smm_mode(smm_mode), .smm_base(smm_base)
);

// File: tb/test_cfg_index_port.sv
`timescale 1ns/1ps
module test_cfg_index_port;
  logic        clk = 1'b0;
  logic        rst_n, init, io_valid, io_write, in_smm;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic        io_hit, io_fwd;
  logic [7:0]  io_rdata;
  logic [3:0]  page_sel;
  logic        smi_lock, nmi_en, smm_rgn_en, smm_mode;
  logic [23:0] smm_base;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  cfg_index_port i_cfg_index_port (
    .clk(clk), .rst_n(rst_n), .init(init), .io_valid(io_valid), .io_write(io_write),
    .io_addr(io_addr), .io_wdata(io_wdata), .in_smm(in_smm),
    .io_hit(io_hit), .io_fwd(io_fwd), .io_rdata(io_rdata),
    .page_sel(page_sel), .smi_lock(smi_lock), .nmi_en(nmi_en),
    .smm_rgn_en(smm_rgn_en), .smm_mode(smm_mode), .smm_base(smm_base)
  );

  // vector: [31:28] req, [27] wr, [26:19] addr, [18:11] wdata, [10] smm, [9] hit, [8] fwd, [7:0] rdata
  function automatic logic [31:0] mk(input int req, input bit wr, input logic [7:0] a,
                                     input logic [7:0] wd, input bit smm, input bit hit,
                                     input bit fwd, input logic [7:0] rd);
    return {4'(req), wr, a, wd, smm, hit, fwd, rd};
  endfunction

  localparam int NV = 43;
  localparam logic [31:0] VEC [NV] = '{
    mk(2, 0, 8'h22, 8'h00, 0, 0, 1, 8'h00), // R2 index read forwarded
    mk(1, 0, 8'h23, 8'h00, 0, 0, 1, 8'h00), // R1 no index pending
    mk(2, 1, 8'h22, 8'hC1, 0, 1, 0, 8'h00), // R2 index write absorbed
    mk(5, 1, 8'h23, 8'h80, 0, 1, 0, 8'h00), // R5 region enable set
    mk(3, 0, 8'h23, 8'h00, 0, 0, 1, 8'h00), // R3 index consumed
    mk(2, 1, 8'h22, 8'hC1, 0, 1, 0, 8'h00),
    mk(5, 0, 8'h23, 8'h00, 0, 1, 0, 8'h80), // R5 readback C1
    mk(2, 1, 8'h22, 8'hEA, 0, 1, 0, 8'h00),
    mk(4, 0, 8'h23, 8'h00, 0, 0, 1, 8'h00), // R4 EA hidden on page 0
    mk(2, 1, 8'h22, 8'hC3, 0, 1, 0, 8'h00),
    mk(4, 1, 8'h23, 8'h10, 0, 1, 0, 8'h00), // R4 page 0001
    mk(2, 1, 8'h22, 8'hEA, 0, 1, 0, 8'h00),
    mk(4, 1, 8'h23, 8'h01, 0, 1, 0, 8'h00), // R4 EA visible now
    mk(2, 1, 8'h22, 8'hEA, 0, 1, 0, 8'h00),
    mk(4, 0, 8'h23, 8'h00, 0, 1, 0, 8'h01), // R4 mode readback
    mk(2, 1, 8'h22, 8'hC4, 0, 1, 0, 8'h00),
    mk(5, 1, 8'h23, 8'h5A, 0, 1, 0, 8'h00), // R5 base byte 0
    mk(2, 1, 8'h22, 8'hC4, 0, 1, 0, 8'h00),
    mk(5, 0, 8'h23, 8'h00, 0, 1, 0, 8'h5A), // R5 base readback
    mk(2, 1, 8'h22, 8'hFD, 0, 1, 0, 8'h00),
    mk(5, 0, 8'h23, 8'h00, 0, 0, 1, 8'h00), // R5 reserved visible index forwarded
    mk(2, 1, 8'h22, 8'hC3, 0, 1, 0, 8'h00),
    mk(6, 1, 8'h23, 8'h13, 0, 1, 0, 8'h00), // R6 set lock, nmi, page1
    mk(2, 1, 8'h22, 8'hC1, 0, 1, 0, 8'h00),
    mk(6, 1, 8'h23, 8'h00, 0, 1, 0, 8'h00), // R6 blocked write still hit
    mk(2, 1, 8'h22, 8'hC1, 0, 1, 0, 8'h00),
    mk(6, 0, 8'h23, 8'h00, 0, 1, 0, 8'h80), // R6 region enable kept
    mk(2, 1, 8'h22, 8'hC4, 0, 1, 0, 8'h00),
    mk(6, 1, 8'h23, 8'h00, 0, 1, 0, 8'h00),
    mk(2, 1, 8'h22, 8'hC4, 0, 1, 0, 8'h00),
    mk(6, 0, 8'h23, 8'h00, 0, 1, 0, 8'h5A), // R6 base kept
    mk(2, 1, 8'h22, 8'hC3, 0, 1, 0, 8'h00),
    mk(7, 1, 8'h23, 8'h10, 0, 1, 0, 8'h00), // R7 try to clear lock, nmi
    mk(2, 1, 8'h22, 8'hC3, 0, 1, 0, 8'h00),
    mk(7, 0, 8'h23, 8'h00, 0, 1, 0, 8'h13), // R7 lock and nmi kept
    mk(2, 1, 8'h22, 8'hC1, 1, 1, 0, 8'h00),
    mk(6, 1, 8'h23, 8'h00, 1, 1, 0, 8'h00), // R6 write inside SMM
    mk(2, 1, 8'h22, 8'hC1, 1, 1, 0, 8'h00),
    mk(6, 0, 8'h23, 8'h00, 1, 1, 0, 8'h00), // R6 region enable cleared
    mk(2, 1, 8'h22, 8'hC3, 1, 1, 0, 8'h00),
    mk(7, 1, 8'h23, 8'h00, 1, 1, 0, 8'h00), // R7 lock stays even in SMM
    mk(2, 1, 8'h22, 8'hC3, 1, 1, 0, 8'h00),
    mk(7, 0, 8'h23, 8'h00, 1, 1, 0, 8'h01)  // R7 page 0, nmi 0, lock 1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input bit wr, input logic [7:0] a,
                       input logic [7:0] wd, input bit smm);
    @(negedge clk);
    io_valid = v; io_write = wr; io_addr = {8'h00, a}; io_wdata = wd; in_smm = smm;
    #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; init = 1'b0; io_valid = 1'b0; io_write = 1'b0;
    io_addr = '0; io_wdata = '0; in_smm = 1'b0;
    #7;
    // R9 reset state
    chk("R9", {io_hit, io_fwd, io_rdata, page_sel, smi_lock, nmi_en, smm_rgn_en, smm_mode, smm_base},
        32'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      string tag;
      v = VEC[i];
      drive(1'b1, v[27], v[26:19], v[18:11], v[10]);
      tag = $sformatf("R%0d vec%0d", v[31:28], i);
      chk(tag, {22'b0, io_hit, io_fwd, io_rdata}, {22'b0, v[9:8], v[7:0]});
      chk("R10", {31'b0, io_hit ^ io_fwd}, 32'd1);
    end

    // R6 R7 register pins after table
    drive(1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
    chk("R7 pins", {24'b0, page_sel, smi_lock, nmi_en, smm_rgn_en, smm_mode},
        {24'b0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b1});
    chk("R6 base pin", {8'b0, smm_base}, 32'h0000005A);
    chk("R9 idle outputs", {22'b0, io_hit, io_fwd, io_rdata}, 32'h0);

    // R8 init cancels index, registers kept
    drive(1'b1, 1'b1, 8'h22, 8'hC1, 1'b0);
    @(negedge clk); io_valid = 1'b0; init = 1'b1;
    @(negedge clk); init = 1'b0; io_valid = 1'b1; io_write = 1'b0; io_addr = 16'h0023;
    #1;
    chk("R8 fwd after init", {30'b0, io_hit, io_fwd}, 32'd1);
    chk("R8 regs kept", {8'b0, smi_lock, smm_mode, smm_rgn_en, smm_base[20:0]},
        {8'b0, 1'b1, 1'b1, 1'b0, 21'h00005A});

    // R4 page 0 hides EA even inside SMM
    drive(1'b1, 1'b1, 8'h22, 8'hEA, 1'b1);
    drive(1'b1, 1'b0, 8'h23, 8'h00, 1'b1);
    chk("R4 EA hidden", {30'b0, io_hit, io_fwd}, 32'd1);

    // R9 reset clears lock and all fields
    @(negedge clk); io_valid = 1'b0; rst_n = 1'b0;
    #1;
    chk("R9 after reset", {8'b0, page_sel, smi_lock, nmi_en, smm_rgn_en, smm_mode, smm_base[15:0]},
        32'h0);
    @(negedge clk); rst_n = 1'b1;
    drive(1'b1, 1'b0, 8'h23, 8'h00, 1'b0);
    chk("R1 no index after reset", {30'b0, io_hit, io_fwd}, 32'd1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule